// File: doc/BRIEF.md
# Hashed Page-Table Group Address Generator

This block turns an effective address into the physical address of the page-table entry group that may hold its translation. It also produces the 32-bit compare word that the first word of a matching entry must equal. Sixteen segment registers are held inside the block, and the top four address bits pick one of them. A table register supplies the table base and a size field. The size field widens the hash mask, so larger tables use more hash bits.

A caller presents an effective address and a primary/secondary select. Both are captured on a rising clock edge. The group address and compare word then follow combinationally from the captured request and the current register contents. A caller normally asks for the primary group first, then for the secondary group at the same address. Segment and table registers are written through simple write ports. Fetching and comparing table entries is left to the caller.

Top module: `htab_group_addr`

## Requirements
- R1: The segment register used for a lookup is the one whose index equals effective-address bits 31:28; its low 28 bits are the segment ID.
- R2: The primary hash is ((segment ID XOR effective-address bits 27:12) shifted left by 6), kept to 32 bits.
- R3: When the secondary select is 1, the whole 32-bit hash is bitwise inverted before masking, and compare-word bit 6 is set; with select 0 that bit is clear.
- R4: The group address equals (table register bits 31:16 in bits 31:16) OR (hash AND mask), where mask is (table register bits 8:0 shifted left by 16) OR 0xFFC0. Bits 5:0 of the group address are therefore always 0, and bits 31:25 equal table register bits 31:25.
- R5: The compare word has bit 31 set, segment-ID bits 23:0 in bits 30:7, the select in bit 6, and effective-address bits 27:22 in bits 5:0.
- R6: Segment register bits 31:28 (invalid flag, supervisor key, user key and one spare bit) have no effect on either output.
- R7: The address and select are captured on a rising edge, and the outputs reflect them from that edge on. A register write also takes effect at its edge, so the outputs of a held request follow the new contents right after the write edge.
- R8: Reset (active low) clears all segment registers, the table register and the captured request: group address 0x00000000, compare word 0x80000000.
- R9: A segment write changes only the register selected by the 4-bit write index.
- R10: Table register bits 15:9 have no effect on the group address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| effAddr | input | 32 | Effective address of the lookup |
| useSecondary | input | 1 | 1 selects the secondary group, 0 the primary |
| segWrEn | input | 1 | Segment register write strobe |
| segWrIdx | input | 4 | Segment register write index |
| segWrData | input | 32 | Segment register write value |
| tblWrEn | input | 1 | Table register write strobe |
| tblWrData | input | 32 | Table register write value (base in 31:16, size in 8:0) |
| groupAddr | output | 32 | Physical address of the selected entry group |
| cmpWord | output | 32 | Word a matching entry's first word must equal |

## Verification
The hardest case to reach is a request that stays captured while the segment register it uses is rewritten. Here the outputs must change with no new capture. The bench holds one address steady across a write to that same index and samples right after the write edge. The flag bits and the ignored table bits are each changed while the hash inputs stay fixed, and the outputs are compared with their earlier values. The main sweep covers every segment index with several page patterns, both selects, and table sizes from zero to the full size field.

// File: rtl/htab_pkg.sv
package htab_pkg;
  parameter int EA_W        = 32;
  parameter int NUM_SEGS    = 16;
  parameter int SEG_IDX_W   = $clog2(NUM_SEGS);
  parameter int VSID_W      = 28;
  parameter int PAGE_LSB    = 12;
  parameter int PAGE_W      = 16;
  parameter int GROUP_SHIFT = 6;
  parameter int SIZE_W      = 9;
  parameter int BASE_LSB    = 16;
  parameter int API_W       = 6;

  typedef struct packed {
    logic [NUM_SEGS-1:0] segLoad;
    logic                tblLoad;
  } htab_strobe_t;
endpackage

// File: rtl/htab_ctrl.sv
module htab_ctrl
  import htab_pkg::*;
#(
  parameter int NSEG  = NUM_SEGS,
  parameter int IDX_W = SEG_IDX_W,
  parameter int REQ_W = EA_W - PAGE_LSB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               segWrEn,
  input  logic [IDX_W-1:0]   segWrIdx,
  input  logic               tblWrEn,
  input  logic [REQ_W-1:0]   reqIn,
  input  logic               secIn,
  output htab_strobe_t       strobes,
  output logic [REQ_W-1:0]   reqHeld,
  output logic               secHeld
);
  logic [NSEG-1:0] segOneHot;

  for (genvar g = 0; g < NSEG; g++) begin : g_dec
    assign segOneHot[g] = segWrEn && (segWrIdx == IDX_W'(g));
  end

  always_comb begin
    strobes.segLoad = segOneHot;
    strobes.tblLoad = tblWrEn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reqHeld <= '0;
      secHeld <= 1'b0;
    end else begin
      reqHeld <= reqIn;
      secHeld <= secIn;
    end
  end
endmodule

// File: rtl/htab_segfile.sv
module htab_segfile
  import htab_pkg::*;
#(
  parameter int NSEG  = NUM_SEGS,
  parameter int IDX_W = SEG_IDX_W,
  parameter int DW    = VSID_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSEG-1:0]  load,
  input  logic [DW-1:0]    wrData,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [DW-1:0]    rdData
);
  logic [DW-1:0] segRegs [NSEG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEG; i++) segRegs[i] <= '0;
    end else begin
      for (int i = 0; i < NSEG; i++)
        if (load[i]) segRegs[i] <= wrData;
    end
  end

  assign rdData = segRegs[rdIdx];
endmodule

// File: rtl/htab_datapath.sv
module htab_datapath
  import htab_pkg::*;
#(
  parameter int AW     = EA_W,
  parameter int NSEG   = NUM_SEGS,
  parameter int IDX_W  = SEG_IDX_W,
  parameter int VW     = VSID_W,
  parameter int PL     = PAGE_LSB,
  parameter int PW     = PAGE_W,
  parameter int GS     = GROUP_SHIFT,
  parameter int SW     = SIZE_W,
  parameter int BL     = BASE_LSB,
  parameter int AP     = API_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  htab_strobe_t    strobes,
  input  logic [VW-1:0]   segWrVsid,
  input  logic [AW-1:BL]  tblBaseIn,
  input  logic [SW-1:0]   tblSizeIn,
  input  logic [AW-1:PL]  reqHeld,
  input  logic            secHeld,
  output logic [AW-1:0]   groupAddr,
  output logic [AW-1:0]   cmpWord
);
  localparam int HASH_KEEP = AW - GS;
  localparam int MASK_PAD  = AW - BL - SW;
  localparam int CMP_VSID  = AW - 2 - AP;

  logic [AW-1:BL]  tblBase;
  logic [SW-1:0]   tblSize;
  logic [VW-1:0]   vsid;
  logic [VW-1:0]   mixed;
  logic [AW-1:0]   hashPri;
  logic [AW-1:0]   hashSel;
  logic [AW-1:0]   hashMask;
  logic [IDX_W-1:0] segIdx;
  logic [PW-1:0]   pageIdx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tblBase <= '0;
      tblSize <= '0;
    end else if (strobes.tblLoad) begin
      tblBase <= tblBaseIn;
      tblSize <= tblSizeIn;
    end
  end

  assign segIdx  = reqHeld[AW-1 -: IDX_W];
  assign pageIdx = reqHeld[PL +: PW];

  htab_segfile #(.NSEG(NSEG), .IDX_W(IDX_W), .DW(VW)) u_segs (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (strobes.segLoad),
    .wrData(segWrVsid),
    .rdIdx (segIdx),
    .rdData(vsid)
  );

  always_comb begin
    mixed    = vsid ^ VW'(pageIdx);
    hashPri  = {mixed[HASH_KEEP-1:0], {GS{1'b0}}};
    hashSel  = secHeld ? ~hashPri : hashPri;
    hashMask = {{MASK_PAD{1'b0}}, tblSize, 16'hFFC0};
    groupAddr = {tblBase, {BL{1'b0}}} | (hashSel & hashMask);
    cmpWord   = {1'b1, vsid[CMP_VSID-1:0], secHeld, reqHeld[PL+PW-1 -: AP]};
  end
endmodule

// File: rtl/htab_group_addr.sv
module htab_group_addr
  import htab_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [EA_W-1:0]      effAddr,
  input  logic                 useSecondary,
  input  logic                 segWrEn,
  input  logic [SEG_IDX_W-1:0] segWrIdx,
  input  logic [EA_W-1:0]      segWrData,
  input  logic                 tblWrEn,
  input  logic [EA_W-1:0]      tblWrData,
  output logic [EA_W-1:0]      groupAddr,
  output logic [EA_W-1:0]      cmpWord
);
  htab_strobe_t          strobes;
  logic [EA_W-1:PAGE_LSB] reqHeld;
  logic                  secHeld;
  logic                  unusedBits;

  assign unusedBits = ^{effAddr[PAGE_LSB-1:0], segWrData[EA_W-1:VSID_W],
                        tblWrData[BASE_LSB-1:SIZE_W]};

  htab_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .segWrEn (segWrEn),
    .segWrIdx(segWrIdx),
    .tblWrEn (tblWrEn),
    .reqIn   (effAddr[EA_W-1:PAGE_LSB]),
    .secIn   (useSecondary),
    .strobes (strobes),
    .reqHeld (reqHeld),
    .secHeld (secHeld)
  );

  htab_datapath u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .segWrVsid(segWrData[VSID_W-1:0]),
    .tblBaseIn(tblWrData[EA_W-1:BASE_LSB]),
    .tblSizeIn(tblWrData[SIZE_W-1:0]),
    .reqHeld  (reqHeld),
    .secHeld  (secHeld),
    .groupAddr(groupAddr),
    .cmpWord  (cmpWord)
  );
endmodule

// File: rtl/htab_group_addr_chk.sv
module htab_group_addr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [5:0]  eaApi,
  input logic        sel,
  input logic        tblWrEn,
  input logic [6:0]  tblTop,
  input logic [31:0] groupAddr,
  input logic [31:0] cmpWord
);
  // R4
  group_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    groupAddr[5:0] == 6'd0);

  // R5
  cmp_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmpWord[31]);

  // R5
  cmp_api_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cmpWord[5:0] == $past(eaApi));

  // R3
  cmp_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cmpWord[6] == $past(sel));

  // R4
  group_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(tblWrEn)) |-> groupAddr[31:25] == $past(tblTop));
endmodule

bind htab_group_addr htab_group_addr_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .eaApi    (effAddr[27:22]),
  .sel      (useSecondary),
  .tblWrEn  (tblWrEn),
  .tblTop   (tblWrData[31:25]),
  .groupAddr(groupAddr),
  .cmpWord  (cmpWord)
);

// File: tb/htab_group_addr_bench.sv
module htab_group_addr_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] effAddr = '0;
  logic        useSecondary = 1'b0;
  logic        segWrEn = 1'b0;
  logic [3:0]  segWrIdx = '0;
  logic [31:0] segWrData = '0;
  logic        tblWrEn = 1'b0;
  logic [31:0] tblWrData = '0;
  logic [31:0] groupAddr;
  logic [31:0] cmpWord;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  logic [31:0] segModel [16];
  logic [31:0] tblModel = '0;

  htab_group_addr u_htab_group_addr (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [31:0] mGroup(logic [31:0] ea, logic sec);
    logic [31:0] v, h, m;
    v = segModel[ea >> 28] & 32'h0FFF_FFFF;
    h = (v ^ ((ea >> 12) & 32'hFFFF)) << 6;
    if (sec) h = ~h;
    m = ((tblModel & 32'h1FF) << 16) | 32'hFFC0;
    return (tblModel & 32'hFFFF_0000) | (h & m);
  endfunction

  function automatic logic [31:0] mCmp(logic [31:0] ea, logic sec);
    logic [31:0] v;
    v = segModel[ea >> 28] & 32'h0FFF_FFFF;
    return 32'h8000_0000 | (v << 7) | (sec ? 32'h40 : 32'h0) | ((ea >> 22) & 32'h3F);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeSeg(int idx, logic [31:0] val);
    @(negedge clk);
    segWrEn = 1'b1; segWrIdx = 4'(idx); segWrData = val;
    @(negedge clk);
    segWrEn = 1'b0;
    segModel[idx] = val;
  endtask

  task automatic writeTbl(logic [31:0] val);
    @(negedge clk);
    tblWrEn = 1'b1; tblWrData = val;
    @(negedge clk);
    tblWrEn = 1'b0;
    tblModel = val;
  endtask

  task automatic lookup(logic [31:0] ea, logic sec, string req);
    @(negedge clk);
    effAddr = ea; useSecondary = sec;
    @(negedge clk);
    chk({req, " group"}, groupAddr, mGroup(ea, sec));
    chk({req, " cmp"}, cmpWord, mCmp(ea, sec));
  endtask

  initial begin
    logic [31:0] g0, c0;
    logic [15:0] pages [4];
    for (int i = 0; i < 16; i++) segModel[i] = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 reset group", groupAddr, 32'h0000_0000);
    chk("R8 reset cmp", cmpWord, 32'h8000_0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 after release group", groupAddr, 32'h0000_0000);

    writeTbl(32'h5A30_00F3);
    for (int i = 0; i < 16; i++)
      writeSeg(i, (32'(i) << 28) | ((32'(i) * 32'h0123_4567 ^ 32'h09AB_CDEF) & 32'h0FFF_FFFF));

    // R1 R2 R3 R5: every segment, several pages, both selects
    for (int i = 0; i < 16; i++) begin
      pages[0] = 16'h0000; pages[1] = 16'hFFFF; pages[2] = 16'hA5C3;
      pages[3] = 16'(i * 16'h1111);
      for (int p = 0; p < 4; p++)
        for (int s = 0; s < 2; s++)
          lookup({4'(i), pages[p], 12'h9E1}, 1'(s), "R1 R2 R3 R5 sweep");
    end

    // R4: table sizes from empty to full size field
    for (int b = 0; b < 5; b++) begin
      case (b)
        0: writeTbl(32'hABCD_0000);
        1: writeTbl(32'h0010_01FF);
        2: writeTbl(32'h7F80_00AA);
        3: writeTbl(32'hFFFF_0155);
        default: writeTbl(32'h0000_0001);
      endcase
      for (int k = 0; k < 6; k++)
        for (int s = 0; s < 2; s++)
          lookup({4'(k * 3), 16'(k * 16'h2F1D + 16'h0777), 12'h0}, 1'(s), "R4 table size");
    end

    // R10: table bits 15:9 ignored
    writeTbl(32'h3C00_0123);
    lookup(32'h7BEE_F000, 1'b1, "R10 base");
    g0 = groupAddr;
    writeTbl(32'h3C00_FF23);
    @(negedge clk);
    chk("R10 ignored table bits", groupAddr, g0);

    // R6: segment flag bits ignored
    lookup(32'h5123_4000, 1'b0, "R6 base");
    g0 = groupAddr; c0 = cmpWord;
    writeSeg(5, (segModel[5] & 32'h0FFF_FFFF) | 32'hF000_0000);
    chk("R6 flags group", groupAddr, g0);
    chk("R6 flags cmp", cmpWord, c0);
    writeSeg(5, segModel[5] & 32'h0FFF_FFFF);
    chk("R6 flags cleared cmp", cmpWord, c0);

    // R9: write to one index leaves neighbours intact
    writeSeg(3, 32'h0DEA_DBEE);
    lookup(32'h4555_5000, 1'b0, "R9 neighbour 4");
    lookup(32'h2555_5000, 1'b1, "R9 neighbour 2");
    lookup(32'h3555_5000, 1'b0, "R9 written 3");

    // R7: held request follows a write to its own segment
    @(negedge clk);
    effAddr = 32'h7ABC_D000; useSecondary = 1'b1;
    @(negedge clk);
    chk("R7 before write", cmpWord, mCmp(32'h7ABC_D000, 1'b1));
    segWrEn = 1'b1; segWrIdx = 4'd7; segWrData = 32'h0135_7913;
    @(negedge clk);
    segWrEn = 1'b0;
    segModel[7] = 32'h0135_7913;
    chk("R7 after write group", groupAddr, mGroup(32'h7ABC_D000, 1'b1));
    chk("R7 after write cmp", cmpWord, mCmp(32'h7ABC_D000, 1'b1));
    // R7: new address shows only after capture edge
    effAddr = 32'h0000_0000; useSecondary = 1'b0;
    #1;
    chk("R7 not yet captured", cmpWord, mCmp(32'h7ABC_D000, 1'b1));
    @(negedge clk);
    chk("R7 captured", cmpWord, mCmp(32'h0000_0000, 1'b0));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule